// File: doc/BRIEF.md
# Two-into-one four-phase handshake mixer

This control block joins several passive four-phase (return-to-zero) request/acknowledge ports onto a single active port. A request arriving on any input port is passed on as the outgoing request; the acknowledge that comes back is returned only to the input port that made the request. The block follows that port through the whole return-to-zero cycle, so the falling acknowledge goes to the same port as the rising one. The default build has two input ports: port 0 (bit 0 of the vectors) and port 1 (bit 1).

The block does no arbitration. Its environment must never hold two input requests high in the same cycle. The model is synchronous to `clk`, and every output comes from a register. A low level on `rst_n` clears the outputs at once. Release of `rst_n` passes through a short synchronizer before the sequencing logic starts. An input request that arrives while an earlier return-to-zero has not finished is held off until that cycle ends.

Top module: `hs_mixer`

## Requirements
- R1: While `rst_n` is low, `out_req` and every bit of `in_ack` are 0, and they clear at once when `rst_n` falls. After `rst_n` rises, requests have no effect for two clock edges. A request held high across the release raises `out_req` after the third edge.
- R2: At most one bit of `in_ack` is high at any time. The environment keeps at most one bit of `in_req` high.
- R3: When the block is idle and bit i of `in_req` is sampled high at a clock edge, `out_req` is 1 after that edge.
- R4: One edge after `out_ack` is sampled high, `in_ack` equals the one-hot code of the port being served (bit i set for port i). No bit of `in_ack` rises before `out_ack` has been seen high.
- R5: While the served port's request stays high, its acknowledge and `out_req` both stay high.
- R6: One edge after the served port's request is sampled low, `out_req` is 0. The served port's acknowledge stays high at that point.
- R7: The served port's acknowledge stays high until `out_ack` is sampled low, and is 0 one edge later.
- R8: A request from another port that arrives before `out_ack` has fallen is held off, with `out_req` 0 and no acknowledge given to that port. It raises `out_req` two edges after `out_ack` is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| in_req | input | NUM_IN | Request of each passive input port, bit i for port i |
| in_ack | output | NUM_IN | Acknowledge to each passive input port, bit i for port i |
| out_req | output | 1 | Request of the active merged port |
| out_ack | input | 1 | Acknowledge returned on the active merged port |

## Verification
The assertions rely on the environment keeping the four-phase rules on every port. No two input requests are high together. An input request falls only after its acknowledge has risen and rises again only after the acknowledge has fallen. `out_ack` follows `out_req` in the same alternating way. The bench drives every port from tasks that apply these steps in order and keeps a monitor of its own on the request vector. The only overlap it creates is a second port raising its request after the first port's request has already dropped, which is the case R8 describes.

// File: rtl/mix_pkg.sv
package mix_pkg;

  // Phase of the served handshake cycle
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // nothing in flight
    PH_RAISE = 2'd1,  // outgoing request up, waiting for its acknowledge
    PH_HOLD  = 2'd2,  // input acknowledged, waiting for its request to drop
    PH_RTZ   = 2'd3   // outgoing request down, waiting for acknowledge to drop
  } mix_phase_e;

endpackage

// File: rtl/mix_rst_sync.sv
module mix_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mix_owner_track.sv
module mix_owner_track #(
  parameter int NUM_IN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] in_req,
  input  logic              grant_evt,
  output logic [NUM_IN-1:0] owner,
  output logic              any_req,
  output logic              owner_req
);

  logic [NUM_IN-1:0] pick;
  logic              found;
  logic [NUM_IN-1:0] owner_nxt;
  logic              owner_en;

  // Lowest index wins; with a mutually exclusive environment only one bit is set
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (in_req[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign any_req   = |in_req;
  assign owner_en  = grant_evt;
  assign owner_nxt = pick;
  assign owner_req = |(in_req & owner);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        owner <= '0;
    else if (owner_en) owner <= owner_nxt;
  end

endmodule

// File: rtl/mix_phase_fsm.sv
module mix_phase_fsm
  import mix_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_req,
  input  logic       owner_req,
  input  logic       out_ack,
  output mix_phase_e phase,
  output logic       out_req,
  output logic       grant_evt,
  output logic       ack_set_evt,
  output logic       ack_clr_evt
);

  mix_phase_e phase_nxt;
  logic       req_nxt;
  logic       phase_en;
  logic       req_en;

  always_comb begin
    phase_nxt   = phase;
    req_nxt     = out_req;
    grant_evt   = 1'b0;
    ack_set_evt = 1'b0;
    ack_clr_evt = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (any_req) begin
          phase_nxt = PH_RAISE;
          req_nxt   = 1'b1;
          grant_evt = 1'b1;
        end
      end
      PH_RAISE: begin
        if (out_ack) begin
          phase_nxt   = PH_HOLD;
          ack_set_evt = 1'b1;
        end
      end
      PH_HOLD: begin
        if (!owner_req) begin
          phase_nxt = PH_RTZ;
          req_nxt   = 1'b0;
        end
      end
      PH_RTZ: begin
        if (!out_ack) begin
          phase_nxt   = PH_IDLE;
          ack_clr_evt = 1'b1;
        end
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  assign phase_en = (phase_nxt != phase);
  assign req_en   = (req_nxt != out_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      out_req <= 1'b0;
    end else begin
      if (phase_en) phase   <= phase_nxt;
      if (req_en)   out_req <= req_nxt;
    end
  end

endmodule

// File: rtl/mix_ack_steer.sv
module mix_ack_steer #(
  parameter int NUM_IN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] owner,
  input  logic              ack_set_evt,
  input  logic              ack_clr_evt,
  output logic [NUM_IN-1:0] in_ack
);

  generate
    for (genvar g = 0; g < NUM_IN; g++) begin : g_port
      logic ack_q;
      logic ack_en;
      logic ack_nxt;

      // Only the port recorded as owner is touched by set or clear
      assign ack_en  = owner[g] & (ack_set_evt | ack_clr_evt);
      assign ack_nxt = ack_set_evt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ack_q <= 1'b0;
        else if (ack_en) ack_q <= ack_nxt;
      end

      assign in_ack[g] = ack_q;
    end
  endgenerate

endmodule

// File: rtl/hs_mixer.sv
module hs_mixer
  import mix_pkg::*;
#(
  parameter int NUM_IN     = 2,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] in_req,
  output logic [NUM_IN-1:0] in_ack,
  output logic              out_req,
  input  logic              out_ack
);

  logic              rst_int_n;
  logic [NUM_IN-1:0] owner;
  logic              any_req;
  logic              owner_req;
  logic              grant_evt;
  logic              ack_set_evt;
  logic              ack_clr_evt;
  mix_phase_e        phase;

  mix_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mix_owner_track #(.NUM_IN(NUM_IN)) u_owner (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_req    (in_req),
    .grant_evt (grant_evt),
    .owner     (owner),
    .any_req   (any_req),
    .owner_req (owner_req)
  );

  mix_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .any_req     (any_req),
    .owner_req   (owner_req),
    .out_ack     (out_ack),
    .phase       (phase),
    .out_req     (out_req),
    .grant_evt   (grant_evt),
    .ack_set_evt (ack_set_evt),
    .ack_clr_evt (ack_clr_evt)
  );

  mix_ack_steer #(.NUM_IN(NUM_IN)) u_steer (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .owner       (owner),
    .ack_set_evt (ack_set_evt),
    .ack_clr_evt (ack_clr_evt),
    .in_ack      (in_ack)
  );

endmodule

// File: rtl/mix_checker.sv
module mix_checker #(
  parameter int NUM_IN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_IN-1:0] in_req,
  input logic [NUM_IN-1:0] in_ack,
  input logic              out_req,
  input logic              out_ack
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!out_req && (in_ack == '0))); // R1

  AST_ACK_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ack)); // R2

  AST_INPUT_MUTEX: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_req) <= 1); // R2

  AST_REQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> $past(|in_req)); // R3

  AST_REQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_req) |-> $past(|in_ack)); // R6

  generate
    for (genvar g = 0; g < NUM_IN; g++) begin : g_chk
      AST_ACK_RISE_AFTER_CACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack[g]) |-> ($past(out_ack) && $past(in_req[g]))); // R4

      AST_ACK_KEPT_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack[g] && in_req[g]) |=> in_ack[g]); // R5

      AST_ACK_FALL_AFTER_CACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ack[g]) |-> (!$past(out_ack) && !$past(in_req[g]))); // R7
    end
  endgenerate

endmodule

bind hs_mixer mix_checker #(.NUM_IN(NUM_IN)) u_mix_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_req  (in_req),
  .in_ack  (in_ack),
  .out_req (out_req),
  .out_ack (out_ack)
);

// File: tb/test_hs_mixer.sv
`timescale 1ns/1ps
module test_hs_mixer;

  logic       clk;
  logic       rst_n;
  logic [1:0] req;
  logic [1:0] ack;
  logic       c_req;
  logic       c_ack;

  int n_chk;
  int n_bad;
  int mutex_viol;
  bit done;

  hs_mixer #(.NUM_IN(2), .RST_STAGES(2)) i_hs_mixer (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_req  (req),
    .in_ack  (ack),
    .out_req (c_req),
    .out_ack (c_ack)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Stimulus-side mutual exclusion monitor (R2)
  always @(negedge clk) if (req == 2'b11) mutex_viol++;

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [1:0] cr();
    return {1'b0, c_req};
  endfunction

  // One full four-phase cycle on port p with environment delays
  task automatic serve(input int p, input int d1, input int d2, input int d3, input int d4);
    logic [1:0] pm;
    pm = (p == 0) ? 2'b01 : 2'b10;
    chk("R3 idle out_req low", cr(), 2'b00);
    chk("R2 idle acks low", ack, 2'b00);
    req[p] = 1'b1;
    step();
    chk("R3 out_req raised", cr(), 2'b01);
    chk("R4 no ack before out_ack", ack, 2'b00);
    for (int k = 0; k < d1; k++) begin
      step();
      chk("R4 ack waits for out_ack", ack, 2'b00);
      chk("R3 out_req held", cr(), 2'b01);
    end
    c_ack = 1'b1;
    step();
    chk("R4 ack to requester only", ack, pm);
    chk("R5 out_req kept", cr(), 2'b01);
    for (int k = 0; k < d2; k++) begin
      step();
      chk("R5 ack held", ack, pm);
      chk("R5 out_req held", cr(), 2'b01);
    end
    req[p] = 1'b0;
    step();
    chk("R6 out_req lowered", cr(), 2'b00);
    chk("R6 ack kept", ack, pm);
    for (int k = 0; k < d3; k++) begin
      step();
      chk("R7 ack not dropped early", ack, pm);
    end
    c_ack = 1'b0;
    step();
    chk("R7 ack lowered", ack, 2'b00);
    for (int k = 0; k < d4; k++) begin
      step();
      chk("R7 stays idle", ack, 2'b00);
      chk("R3 no spurious out_req", cr(), 2'b00);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; mutex_viol = 0; done = 0;
    rst_n = 1'b0; req = 2'b00; c_ack = 1'b0;
    repeat (3) step();
    chk("R1 reset out_req", cr(), 2'b00);
    chk("R1 reset acks", ack, 2'b00);
    req[0] = 1'b1;
    step();
    chk("R1 request ignored in reset", cr(), 2'b00);
    // Release with request held high
    rst_n = 1'b1;
    step();
    chk("R1 sync edge 1", cr(), 2'b00);
    step();
    chk("R1 sync edge 2", cr(), 2'b00);
    step();
    chk("R1 served after sync", cr(), 2'b01);
    c_ack = 1'b1; step();
    chk("R4 ack after release", ack, 2'b01);
    req[0] = 1'b0; step();
    c_ack = 1'b0; step();
    chk("R7 ack low after release cycle", ack, 2'b00);
    step();

    // Near-exhaustive sweep of port and environment delays
    for (int p = 0; p < 2; p++)
      for (int d1 = 0; d1 < 3; d1++)
        for (int d2 = 0; d2 < 3; d2++)
          for (int d3 = 0; d3 < 3; d3++)
            for (int d4 = 0; d4 < 2; d4++)
              serve(p, d1, d2, d3, d4);

    // Alternating ports back to back
    for (int n = 0; n < 6; n++) serve(n % 2, 1, 0, 1, 0);

    // Second port arrives during return-to-zero of the first
    req[0] = 1'b1; step();
    c_ack = 1'b1; step();
    chk("R4 port0 acked", ack, 2'b01);
    req[0] = 1'b0; step();
    chk("R6 out_req low before overlap", cr(), 2'b00);
    req[1] = 1'b1; step();
    chk("R8 late request held off", cr(), 2'b00);
    chk("R8 no ack to late port", ack, 2'b01);
    step();
    chk("R8 still held off", cr(), 2'b00);
    c_ack = 1'b0; step();
    chk("R8 first ack dropped", ack, 2'b00);
    chk("R8 out_req not yet", cr(), 2'b00);
    step();
    chk("R8 late request forwarded", cr(), 2'b01);
    c_ack = 1'b1; step();
    chk("R8 late port acked", ack, 2'b10);
    req[1] = 1'b0; step();
    c_ack = 1'b0; step();
    chk("R8 late cycle done", ack, 2'b00);

    // Reset in the middle of a served cycle
    req[1] = 1'b1; step();
    c_ack = 1'b1; step();
    chk("R4 before mid reset", ack, 2'b10);
    rst_n = 1'b0; #1;
    chk("R1 async clear acks", ack, 2'b00);
    chk("R1 async clear out_req", cr(), 2'b00);
    req = 2'b00; c_ack = 1'b0; step();
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 idle after mid reset", ack, 2'b00);
    serve(0, 0, 0, 0, 1);

    chk("R2 stimulus kept requests exclusive", (mutex_viol != 0) ? 2'b01 : 2'b00, 2'b00);
    done = 1;
    summary();
    $finish;
  end

endmodule